// File: doc/BRIEF.md
# GPIO Pin Configuration and Edge Interrupt Unit

This block owns six pins of an 8-bit port, the pins numbered 2 through 7. A register per pin sets the pad controls (drive enable, open-drain, pull-up, input threshold select), the interrupt polarity and the interrupt enable. A shared port data register holds the value each pin drives. Pins 2, 3 and 4 are edge interrupt inputs, and each has its own request line to the interrupt controller. Pins 5, 6 and 7 share one GPIO request line. Pins 5 and 6 can drive a pulse from an outside timer in place of their data bit. They also feed a timer capture input.

Every pin has a sticky pending flag. A flag is set by an active edge on the value the pin actually carries. For a pin set as an input, that value is the synchronised pad. For a pin set as an output, it is the value being driven. Firmware can therefore raise an interrupt by writing the data bit of an output pin. Firmware can also clear a flag after it changes a polarity bit, since that change can look like an edge. The register bus carries no data stream. It accepts a write on every cycle and never applies back-pressure. The read data is a combinational function of the address.

Top module: `gpio_pincfg`

## Requirements
- R1: After reset, every configuration register, the data register and all pending flags are zero. No pad is driven and every interrupt request is low.
- R2: The data register is at address 0x00, with bits 7:2 holding pins 7:2. The configuration for pin p is at address 0x05+p (0x07..0x0C). Its layout is: bit 0 drive enable, bit 1 pull-up, bit 2 open-drain, bit 4 threshold select, bit 5 active-low, bit 6 interrupt enable, and bit 7 timer output select (pins 5 and 6 only). Registers read back what was written. The pull-up and threshold bits pass straight to pad_pu and pad_ttl.
- R3: When the drive enable is set and open-drain is clear, pad_oe=1 and pad_out equals the drive value. When open-drain is set, a drive value of 0 gives pad_oe=1 and pad_out=0, and a drive value of 1 releases the pad (pad_oe=0). When the drive enable is clear, pad_oe=0 and pad_out=0.
- R4: With timer select and drive enable both set, pin 5 drives tmr_pulse[0] and pin 6 drives tmr_pulse[1] instead of their data bits. The interrupt enable has no effect on this. With drive enable clear, the timer select does nothing.
- R5: For pins 2..4, a rising edge sets the pending flag when active-low is 0, and a falling edge sets it when active-low is 1. The opposite edge sets nothing. A pad edge shows as a pending flag within four cycles. irq_ext[i] (pin i+2) is high exactly while that pin's flag and enable are both set.
- R6: Pending flags read at address 0x0D, bits 7:2. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the flag stays set.
- R7: On a pin with drive enable set, writing its data bit to the active level sets the pending flag within two cycles.
- R8: irq_gpio is high while any of pins 5..7 has both its pending flag and its enable set. A flag set on a pin whose enable is clear does not raise it.
- R9: tmr_cap[0] and tmr_cap[1] carry the value observed on pins 5 and 6. For an output pin this is the drive value. For an input pin it is the pad value after synchronisation.
- R10: Configuration bit 3 always reads 0. Bit 7 reads 0 on pins other than 5 and 6. Writes to these bits have no effect. Unmapped addresses read 0.
- R11: A change of the active-low bit that makes the current level active sets the pending flag. For example, setting active-low while the pin is low sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 6 | Pad input levels, pins 7:2 |
| pad_oe | output | 6 | Pad drive enable |
| pad_out | output | 6 | Pad drive level |
| pad_pu | output | 6 | Pull-up enable |
| pad_ttl | output | 6 | Threshold select |
| tmr_pulse | input | 2 | Timer pulses for pins 5 and 6 |
| tmr_cap | output | 2 | Timer capture inputs from pins 5 and 6 |
| irq_ext | output | 3 | Dedicated requests for pins 2..4 |
| irq_gpio | output | 1 | Shared request for pins 5..7 |

## Verification
A corrupted configuration register shows on the pad controls or on bus_rdata in the cycle after the write. A wrong edge detector or synchroniser state appears as a pending flag that is missing or spurious, three cycles after a pad change or one cycle after a write. A lost pending flag drops the request line at once. A flag that fails to clear keeps the request line high after the clearing write.

// File: rtl/gpio_pincfg_pkg.sv
package gpio_pincfg_pkg;

  localparam int NUM_PINS  = 6;
  localparam int PIN_BASE  = 2;
  localparam int NUM_EXT   = 3;
  localparam int TMR_FIRST = 3;
  localparam int NUM_TMR   = 2;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;

  localparam logic [7:0] DATA_ADDR = 8'h00;
  localparam logic [7:0] CFG_BASE  = 8'h07;
  localparam logic [7:0] PEND_ADDR = 8'h0D;

  typedef struct packed {
    logic tio_sel;
    logic int_en;
    logic act_low;
    logic ttl;
    logic rsvd;
    logic od;
    logic pu;
    logic oe;
  } pin_cfg_t;

  function automatic pin_cfg_t cfg_sanitize(input logic [7:0] raw, input logic has_tmr);
    pin_cfg_t c;
    c = pin_cfg_t'(raw);
    c.rsvd = 1'b0;
    if (!has_tmr) c.tio_sel = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter bit HAS_TMR = 1'b0
) (
  input  logic oe,
  input  logic od,
  input  logic tio_sel,
  input  logic data_bit,
  input  logic tmr_pulse,
  output logic drive_val,
  output logic pad_oe,
  output logic pad_out
);
  logic use_tmr;

  generate
    if (HAS_TMR) begin : g_tmr
      assign use_tmr = tio_sel & oe;
    end else begin : g_plain
      assign use_tmr = 1'b0 & tio_sel;
    end
  endgenerate

  assign drive_val = use_tmr ? tmr_pulse : data_bit;
  // open drain: only a low level is actively driven
  assign pad_oe  = oe & (~od | ~drive_val);
  assign pad_out = oe & ~od & drive_val;
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] obs,
  input  logic [W-1:0] act_low,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] pol, prev_q, pend_q;

  // polarised level: an active edge is a 0->1 step of this value
  assign pol = obs ^ act_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pol;
      pend_q <= (pend_q & ~clr) | (pol & ~prev_q);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/gpio_pincfg.sv
module gpio_pincfg
  import gpio_pincfg_pkg::*;
#(
  parameter int NP  = NUM_PINS,
  parameter int NE  = NUM_EXT,
  parameter int NT  = NUM_TMR,
  parameter int TF  = TMR_FIRST,
  parameter int PB  = PIN_BASE,
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NP-1:0] pad_in,
  output logic [NP-1:0] pad_oe,
  output logic [NP-1:0] pad_out,
  output logic [NP-1:0] pad_pu,
  output logic [NP-1:0] pad_ttl,
  input  logic [NT-1:0] tmr_pulse,
  output logic [NT-1:0] tmr_cap,
  output logic [NE-1:0] irq_ext,
  output logic          irq_gpio
);
  localparam int NG = NP - NE;

  pin_cfg_t      cfg_q [NP];
  logic [NP-1:0] data_q;
  logic [NP-1:0] wr_cfg;
  logic          wr_data, wr_pend;
  logic [NP-1:0] pad_sync, drive_v, obs_v;
  logic [NP-1:0] od_v, en_v, al_v, clr_v, pend_v;

  assign wr_data = bus_wr_en && (bus_addr == AW'(DATA_ADDR));
  assign wr_pend = bus_wr_en && (bus_addr == AW'(PEND_ADDR));

  always_comb begin
    for (int k = 0; k < NP; k++) begin
      wr_cfg[k]  = bus_wr_en && (bus_addr == AW'(CFG_BASE) + AW'(k));
      od_v[k]    = cfg_q[k].od;
      en_v[k]    = cfg_q[k].int_en;
      al_v[k]    = cfg_q[k].act_low;
      pad_pu[k]  = cfg_q[k].pu;
      pad_ttl[k] = cfg_q[k].ttl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      for (int k = 0; k < NP; k++) cfg_q[k] <= '0;
    end else begin
      if (wr_data) data_q <= bus_wdata[PB +: NP];
      for (int k = 0; k < NP; k++) begin
        if (wr_cfg[k])
          cfg_q[k] <= cfg_sanitize(bus_wdata[7:0], (k >= TF) && (k < TF + NT));
      end
    end
  end

  gpio_sync2 #(.W(NP)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  for (genvar k = 0; k < NP; k++) begin : g_pin
    if ((k >= TF) && (k < TF + NT)) begin : g_t
      gpio_pin_drive #(.HAS_TMR(1'b1)) drv_i (
        .oe        (cfg_q[k].oe),
        .od        (cfg_q[k].od),
        .tio_sel   (cfg_q[k].tio_sel),
        .data_bit  (data_q[k]),
        .tmr_pulse (tmr_pulse[k-TF]),
        .drive_val (drive_v[k]),
        .pad_oe    (pad_oe[k]),
        .pad_out   (pad_out[k])
      );
    end else begin : g_n
      gpio_pin_drive #(.HAS_TMR(1'b0)) drv_i (
        .oe        (cfg_q[k].oe),
        .od        (cfg_q[k].od),
        .tio_sel   (cfg_q[k].tio_sel),
        .data_bit  (data_q[k]),
        .tmr_pulse (1'b0),
        .drive_val (drive_v[k]),
        .pad_oe    (pad_oe[k]),
        .pad_out   (pad_out[k])
      );
    end
    // observed pin value is taken after the output driver
    assign obs_v[k] = cfg_q[k].oe ? drive_v[k] : pad_sync[k];
  end

  assign clr_v = wr_pend ? bus_wdata[PB +: NP] : '0;

  gpio_edge_pend #(.W(NP)) pend_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .obs     (obs_v),
    .act_low (al_v),
    .clr     (clr_v),
    .pend    (pend_v)
  );

  assign tmr_cap  = obs_v[TF +: NT];
  assign irq_ext  = pend_v[NE-1:0] & en_v[NE-1:0];
  assign irq_gpio = |(pend_v[NP-1 -: NG] & en_v[NP-1 -: NG]);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(DATA_ADDR)) bus_rdata[PB +: NP] = data_q;
    if (bus_addr == AW'(PEND_ADDR)) bus_rdata[PB +: NP] = pend_v;
    for (int k = 0; k < NP; k++) begin
      if (bus_addr == AW'(CFG_BASE) + AW'(k)) bus_rdata[7:0] = cfg_q[k];
    end
  end
endmodule

// File: rtl/gpio_pincfg_chk.sv
module gpio_pincfg_chk
  import gpio_pincfg_pkg::*;
#(
  parameter int NP = NUM_PINS,
  parameter int NE = NUM_EXT,
  parameter int PB = PIN_BASE,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr_en,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [NP-1:0] pad_oe,
  input logic [NP-1:0] pad_out,
  input logic [NE-1:0] irq_ext,
  input logic          irq_gpio,
  input logic [NP-1:0] od_vec,
  input logic [NP-1:0] en_vec,
  input logic [NP-1:0] pend_vec
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (pad_oe == '0) && (pend_vec == '0));

  a_r3_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((od_vec & pad_oe & pad_out) == '0));

  a_r5_ext_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ext & ~en_vec[NE-1:0]) == '0));

  a_r8_gpio_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gpio |-> (pend_vec[NP-1:NE] != '0));

  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr >= AW'(CFG_BASE)) && (bus_addr < AW'(CFG_BASE) + AW'(NP))) |-> (bus_rdata[3] == 1'b0));

  for (genvar k = 0; k < NP; k++) begin : g_pc
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec[k] && !(bus_wr_en && bus_addr == AW'(PEND_ADDR) && bus_wdata[PB+k])) |=> pend_vec[k]);
  end
endmodule

bind gpio_pincfg gpio_pincfg_chk #(.NP(NP), .NE(NE), .PB(PB), .AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .irq_ext   (irq_ext),
  .irq_gpio  (irq_gpio),
  .od_vec    (od_v),
  .en_vec    (en_v),
  .pend_vec  (pend_v)
);

// File: tb/gpio_pincfg_tb_top.sv
`timescale 1ns/1ps
module gpio_pincfg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_oe, pad_out, pad_pu, pad_ttl;
  logic [1:0] tmr_pulse = '0;
  logic [1:0] tmr_cap;
  logic [2:0] irq_ext;
  logic       irq_gpio;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pincfg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_ttl(pad_ttl),
    .tmr_pulse(tmr_pulse), .tmr_cap(tmr_cap), .irq_ext(irq_ext), .irq_gpio(irq_gpio)
  );

  // {cfg, data, tmr, exp_oe, exp_out, exp_pu, exp_ttl}
  localparam logic [41:0] VEC [8] = '{
    {8'h12, 8'hFC, 2'b00, 6'h00, 6'h00, 6'h3F, 6'h3F},
    {8'h01, 8'hFC, 2'b00, 6'h3F, 6'h3F, 6'h00, 6'h00},
    {8'h03, 8'hA8, 2'b00, 6'h3F, 6'h2A, 6'h3F, 6'h00},
    {8'h05, 8'hA8, 2'b00, 6'h15, 6'h00, 6'h00, 6'h00},
    {8'h91, 8'h00, 2'b01, 6'h3F, 6'h08, 6'h00, 6'h3F},
    {8'h81, 8'hFC, 2'b10, 6'h3F, 6'h37, 6'h00, 6'h00},
    {8'h80, 8'hFC, 2'b11, 6'h00, 6'h00, 6'h00, 6'h00},
    {8'h85, 8'h00, 2'b01, 6'h37, 6'h00, 6'h00, 6'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 pad_oe", {2'b0, pad_oe}, 8'h00);
    chk("R1 irq", {4'b0, irq_gpio, irq_ext}, 8'h00);
    for (int a = 0; a <= 13; a++) begin
      rd(8'(a), r);
      chk("R1 reg", r, 8'h00);
    end

    // table of pad drive vectors (R2 R3 R4)
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c, d;
      logic [1:0] t;
      c = VEC[i][41:34]; d = VEC[i][33:26]; t = VEC[i][25:24];
      for (int p = 0; p < 6; p++) wr(8'h07 + 8'(p), c);
      wr(8'h00, d);
      @(negedge clk); tmr_pulse = t;
      #1;
      chk("R3 R4 pad_oe", {2'b0, pad_oe}, {2'b0, VEC[i][23:18]});
      chk("R3 R4 pad_out", {2'b0, pad_out}, {2'b0, VEC[i][17:12]});
      chk("R2 pad_pu", {2'b0, pad_pu}, {2'b0, VEC[i][11:6]});
      chk("R2 pad_ttl", {2'b0, pad_ttl}, {2'b0, VEC[i][5:0]});
      rd(8'h07, r); chk("R2 R10 cfg pin2", r, c & 8'h77);
      rd(8'h0A, r); chk("R2 cfg pin5", r, c & 8'hF7);
      rd(8'h00, r); chk("R2 data", r, d & 8'hFC);
    end

    // interrupt inputs
    tmr_pulse = 2'b00;
    wr(8'h00, 8'h00);
    for (int p = 0; p < 6; p++) wr(8'h07 + 8'(p), 8'h40);
    cyc(2);
    wr(8'h0D, 8'hFC);
    rd(8'h0D, r); chk("R6 cleared", r, 8'h00);
    @(negedge clk); pad_in[0] = 1'b1; cyc(4);
    chk("R5 rise", {5'b0, irq_ext}, 8'h01);
    rd(8'h0D, r); chk("R6 pend read", r, 8'h04);
    wr(8'h0D, 8'h04);
    chk("R6 w1c", {5'b0, irq_ext}, 8'h00);
    @(negedge clk); pad_in[0] = 1'b0; cyc(4);
    chk("R5 fall ignored", {5'b0, irq_ext}, 8'h00);
    wr(8'h07, 8'h60); cyc(2);
    rd(8'h0D, r); chk("R11 polarity flip", r, 8'h04);
    wr(8'h0D, 8'h04);
    @(negedge clk); pad_in[0] = 1'b1; cyc(4);
    chk("R5 rise ignored", {5'b0, irq_ext}, 8'h00);
    @(negedge clk); pad_in[0] = 1'b0; cyc(4);
    chk("R5 fall active low", {5'b0, irq_ext}, 8'h01);
    wr(8'h0D, 8'h00);
    chk("R6 write zero keeps", {5'b0, irq_ext}, 8'h01);
    wr(8'h0D, 8'h04);

    // R7 firmware-raised interrupt
    wr(8'h08, 8'h41);
    cyc(2);
    wr(8'h0D, 8'hFC);
    wr(8'h00, 8'h08); cyc(2);
    chk("R7 irq", {5'b0, irq_ext}, 8'h02);
    chk("R7 pad_out", {2'b0, pad_out}, 8'h02);

    // R8 shared request
    wr(8'h0C, 8'h40);
    @(negedge clk); pad_in[5] = 1'b1; cyc(4);
    chk("R8 gpio irq", {7'b0, irq_gpio}, 8'h01);
    rd(8'h0D, r); chk("R8 pend", r, 8'h88);
    wr(8'h0D, 8'h88);
    chk("R8 cleared", {7'b0, irq_gpio}, 8'h00);
    wr(8'h0B, 8'h00);
    @(negedge clk); pad_in[4] = 1'b1; cyc(4);
    chk("R8 disabled", {7'b0, irq_gpio}, 8'h00);
    rd(8'h0D, r); chk("R8 disabled pend", r, 8'h40);

    // R9 capture path
    wr(8'h0A, 8'h01);
    wr(8'h00, 8'h20); cyc(1);
    chk("R9 cap from data", {6'b0, tmr_cap}, 8'h03);
    wr(8'h0A, 8'h00);
    @(negedge clk); pad_in[3] = 1'b0; cyc(3);
    chk("R9 cap from pad low", {6'b0, tmr_cap}, 8'h02);
    @(negedge clk); pad_in[3] = 1'b1; cyc(3);
    chk("R9 cap from pad high", {6'b0, tmr_cap}, 8'h03);

    // R4 interrupt enable has no effect on timer drive
    wr(8'h0B, 8'hC1);
    @(negedge clk); tmr_pulse = 2'b10; #1;
    chk("R4 with enable", {7'b0, pad_out[4]}, 8'h01);
    wr(8'h0B, 8'h81); #1;
    chk("R4 without enable", {7'b0, pad_out[4]}, 8'h01);
    @(negedge clk); tmr_pulse = 2'b00; #1;
    chk("R4 pulse low", {7'b0, pad_out[4]}, 8'h00);

    // R10 reserved bits and unmapped addresses
    wr(8'h07, 8'hFF);
    rd(8'h07, r); chk("R10 pin2 rsvd", r, 8'h77);
    wr(8'h0A, 8'hFF);
    rd(8'h0A, r); chk("R10 pin5 rsvd", r, 8'hF7);
    rd(8'h05, r); chk("R10 unmapped 05", r, 8'h00);
    rd(8'h0E, r); chk("R10 unmapped 0E", r, 8'h00);

    cyc(2);
    finish_run();
  end
endmodule